// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control surface of a single DMA channel. It holds three 32-bit registers: a byte count, a descriptor pointer that also carries the transfer direction, and a command/status word. A host writes and reads these registers at fixed byte offsets. The block drives the programmed values straight to a DMA engine. It turns a start command into a one-cycle start pulse, but only when the channel is enabled and idle.

The engine signals completion with a one-cycle done pulse. That pulse marks the channel idle again and latches an interrupt. The interrupt stays high until software writes a one to the clear bit. Descriptor fetching and data movement belong to the engine and are not part of this block. Reads are combinational from the read address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the byte count reads 0x00000000, the pointer register reads 0x00000001, the command/status register reads 0x00000010, and both the interrupt and the start pulse are low.
- R2: A write at offset 0x8C stores bits 22:0 as the byte count. Bits 22:0 appear on `xferSize`. Bits 31:23 read as zero.
- R3: A write at offset 0x90 stores bits 31:4 as the first descriptor address and bit 3 as the direction (1 means local memory to host bus). A read returns those fields, bit 0 always as 1 and bits 2:1 as 0. `descAddr` is the stored address with its low four bits zero, and `xferDir` is bit 3.
- R4: Bit 0 of the command/status register at offset 0xA8 is a read/write enable that resets to 0. Bit 4 is a read-only idle flag that resets to 1. All other bits read 0.
- R5: A command/status write with bit 1 = 1 and bit 0 = 1 while the idle flag is 1 raises `engStart` for exactly one cycle and clears the idle flag at the same clock edge. Bit 1 always reads 0.
- R6: A start write while the idle flag is 0, or with bit 0 = 0 in the same write, produces no start pulse and leaves the idle flag unchanged.
- R7: A done pulse sets the idle flag and a sticky interrupt-pending bit, which drives `irq` from the next cycle on.
- R8: A command/status write with bit 3 = 1 clears the pending interrupt, and bit 3 reads 0. If a done pulse arrives in the same cycle, the interrupt stays set.
- R9: Reads at any offset other than 0x8C, 0x90 and 0xA8 return zero. Writes to read-only or reserved bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Write byte offset |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Read byte offset |
| rdData | output | 32 | Read data (combinational) |
| engDone | input | 1 | One-cycle transfer-complete pulse from the engine |
| engStart | output | 1 | One-cycle start pulse to the engine |
| xferSize | output | 23 | Programmed byte count |
| descAddr | output | 32 | First descriptor address, 16-byte aligned |
| xferDir | output | 1 | Direction: 1 means local memory to host bus |
| irq | output | 1 | Channel interrupt, level |

## Verification
A corrupted idle flag shows up at the command/status read one cycle after the write or done that produced it. The next start attempt then either fires when it should not or stays silent when it should fire. A stuck or lost pending bit appears on `irq` on the cycle after the done pulse or the clear write. A bad byte-count or pointer register shows on `xferSize`, `descAddr` and `xferDir` on the very next cycle. The bench compares every output and the read port against a behavioural model on every clock, so each of these faults is reported within one cycle of its cause.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int DATA_W = 32;
  localparam int ALIGN_BITS = 4;
  localparam int DIR_BIT = 3;

  typedef struct packed {
    logic wrSize;
    logic wrPtr;
    logic wrCsr;
  } regStrobes_t;
endpackage

// File: rtl/dma_regs_ctrl.sv
module dma_regs_ctrl
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_SIZE = 8'h8C,
  parameter logic [ADDR_W-1:0] OFF_PTR = 8'h90,
  parameter logic [ADDR_W-1:0] OFF_CSR = 8'hA8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              cmdEnable,
  input  logic              cmdStart,
  input  logic              cmdClear,
  input  logic              engDone,
  output regStrobes_t       strobes,
  output logic              chanEnable,
  output logic              chanIdle,
  output logic              irqPend,
  output logic              engStart
);
  logic startOk;

  always_comb begin
    strobes.wrSize = wrEn && (wrAddr == OFF_SIZE);
    strobes.wrPtr  = wrEn && (wrAddr == OFF_PTR);
    strobes.wrCsr  = wrEn && (wrAddr == OFF_CSR);
  end

  // A start is accepted only when the same write keeps the channel enabled and the channel is idle.
  assign startOk = strobes.wrCsr && cmdStart && cmdEnable && chanIdle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanEnable <= 1'b0;
      chanIdle   <= 1'b1;
      irqPend    <= 1'b0;
      engStart   <= 1'b0;
    end else begin
      if (strobes.wrCsr) chanEnable <= cmdEnable;
      engStart <= startOk;
      if (startOk) chanIdle <= 1'b0;
      else if (engDone) chanIdle <= 1'b1;
      if (engDone) irqPend <= 1'b1;
      else if (strobes.wrCsr && cmdClear) irqPend <= 1'b0;
    end
  end

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);
  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> !chanIdle);
  assert_no_start_disabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrCsr && cmdStart && !cmdEnable) |=> !engStart);
  assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!chanIdle && !engDone) |=> !engStart);
  assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    engDone |=> (irqPend && (chanIdle || engStart)));
  assert_clear_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqPend) |-> $past(strobes.wrCsr && cmdClear));
endmodule

// File: rtl/dma_regs_dp.sv
module dma_regs_dp
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 23,
  parameter logic [ADDR_W-1:0] OFF_SIZE = 8'h8C,
  parameter logic [ADDR_W-1:0] OFF_PTR = 8'h90,
  parameter logic [ADDR_W-1:0] OFF_CSR = 8'hA8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              chanEnable,
  input  logic              chanIdle,
  output logic [DATA_W-1:0] rdData,
  output logic [SIZE_W-1:0] xferSize,
  output logic [DATA_W-1:0] descAddr,
  output logic              xferDir
);
  localparam int PTR_W = DATA_W - ALIGN_BITS;

  logic [SIZE_W-1:0] sizeReg;
  logic [PTR_W-1:0]  ptrReg;
  logic              dirReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeReg <= '0;
      ptrReg  <= '0;
      dirReg  <= 1'b0;
    end else begin
      if (strobes.wrSize) sizeReg <= wrData[SIZE_W-1:0];
      if (strobes.wrPtr) begin
        ptrReg <= wrData[DATA_W-1:ALIGN_BITS];
        dirReg <= wrData[DIR_BIT];
      end
    end
  end

  assign xferSize = sizeReg;
  assign descAddr = {ptrReg, {ALIGN_BITS{1'b0}}};
  assign xferDir  = dirReg;

  always_comb begin
    rdData = '0;
    if (rdAddr == OFF_SIZE) begin
      rdData[SIZE_W-1:0] = sizeReg;
    end else if (rdAddr == OFF_PTR) begin
      rdData = {ptrReg, dirReg, 2'b00, 1'b1};
    end else if (rdAddr == OFF_CSR) begin
      rdData[4] = chanIdle;
      rdData[0] = chanEnable;
    end
  end

  assert_size_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrSize |=> (xferSize == $past(wrData[SIZE_W-1:0])));
  assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrPtr |=> (descAddr[DATA_W-1:ALIGN_BITS] == $past(wrData[DATA_W-1:ALIGN_BITS])
                       && xferDir == $past(wrData[DIR_BIT])));
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrPtr |=> $stable(descAddr));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 23,
  parameter logic [ADDR_W-1:0] OFF_SIZE = 8'h8C,
  parameter logic [ADDR_W-1:0] OFF_PTR = 8'h90,
  parameter logic [ADDR_W-1:0] OFF_CSR = 8'hA8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              engDone,
  output logic              engStart,
  output logic [SIZE_W-1:0] xferSize,
  output logic [DATA_W-1:0] descAddr,
  output logic              xferDir,
  output logic              irq
);
  regStrobes_t strobes;
  logic chanEnable, chanIdle, irqPend;

  dma_regs_ctrl #(.ADDR_W(ADDR_W), .OFF_SIZE(OFF_SIZE), .OFF_PTR(OFF_PTR), .OFF_CSR(OFF_CSR)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .cmdEnable(wrData[0]), .cmdStart(wrData[1]), .cmdClear(wrData[3]),
    .engDone(engDone), .strobes(strobes), .chanEnable(chanEnable),
    .chanIdle(chanIdle), .irqPend(irqPend), .engStart(engStart)
  );

  dma_regs_dp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFF_SIZE(OFF_SIZE), .OFF_PTR(OFF_PTR), .OFF_CSR(OFF_CSR)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .rdAddr(rdAddr),
    .chanEnable(chanEnable), .chanIdle(chanIdle), .rdData(rdData),
    .xferSize(xferSize), .descAddr(descAddr), .xferDir(xferDir)
  );

  assign irq = irqPend;
endmodule

// File: tb/dma_chan_regs_test.sv
`timescale 1ns/1ps
module dma_chan_regs_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0] rdAddr = '0;
  logic engDone = 1'b0;
  logic [31:0] rdData;
  logic engStart, xferDir, irq;
  logic [22:0] xferSize;
  logic [31:0] descAddr;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  dma_chan_regs uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .engDone(engDone), .engStart(engStart),
    .xferSize(xferSize), .descAddr(descAddr), .xferDir(xferDir), .irq(irq)
  );

  always #4 clk = ~clk;

  // Behavioural reference model
  logic [22:0] mSize;
  logic [28:0] mPtr;
  logic mEn, mIdle, mIrq, mStart, mOk;

  always @(posedge clk) begin
    if (!rstN) begin
      mSize <= '0; mPtr <= '0; mEn <= 0; mIdle <= 1; mIrq <= 0; mStart <= 0;
    end else begin
      mOk = wrEn && wrAddr == 8'hA8 && wrData[1] && wrData[0] && mIdle;
      if (wrEn && wrAddr == 8'h8C) mSize <= wrData[22:0];
      if (wrEn && wrAddr == 8'h90) mPtr <= wrData[31:3];
      if (wrEn && wrAddr == 8'hA8) mEn <= wrData[0];
      mStart <= mOk;
      if (mOk) mIdle <= 0; else if (engDone) mIdle <= 1;
      if (engDone) mIrq <= 1; else if (wrEn && wrAddr == 8'hA8 && wrData[3]) mIrq <= 0;
    end
  end

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h8C: return {9'b0, mSize};
      8'h90: return {mPtr, 3'b001};
      8'hA8: return {27'b0, mIdle, 3'b000, mEn};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("[TB] FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison mid-phase
  always @(posedge clk) begin
    #2;
    if (rstN && !finished) begin
      check("R5 engStart", {31'b0, engStart}, {31'b0, mStart});
      check("R7 irq", {31'b0, irq}, {31'b0, mIrq});
      check("R2 xferSize", {9'b0, xferSize}, {9'b0, mSize});
      check("R3 descAddr", descAddr, {mPtr[28:1], 4'b0});
      check("R3 xferDir", {31'b0, xferDir}, {31'b0, mPtr[0]});
      check(rdAddr == 8'hA8 ? "R4 csr read" : rdAddr == 8'h90 ? "R3 ptr read" :
            rdAddr == 8'h8C ? "R2 size read" : "R9 unmapped read", rdData, modelRead(rdAddr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; wrData = '0;
  endtask

  task automatic pulseDone();
    engDone = 1;
    @(negedge clk);
    engDone = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    rdAddr = a; #1;
    check(req, rdData, exp);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("[TB] FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rd("R1 size", 8'h8C, 32'h0);
    rd("R1 ptr", 8'h90, 32'h1);
    rd("R1 csr", 8'hA8, 32'h10);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 engStart", {31'b0, engStart}, 32'h0);
    // R2 size register
    wr(8'h8C, 32'hFFFF_FFFF);
    rd("R2 size mask", 8'h8C, 32'h007F_FFFF);
    // R3 pointer register
    wr(8'h90, 32'hDEAD_BEEF);
    rd("R3 ptr read", 8'h90, 32'hDEAD_BEE9);
    check("R3 descAddr", descAddr, 32'hDEAD_BEE0);
    check("R3 dir", {31'b0, xferDir}, 32'h1);
    wr(8'h90, 32'h1234_5670);
    rd("R3 ptr dir0", 8'h90, 32'h1234_5671);
    // R4 enable
    wr(8'hA8, 32'h1);
    rd("R4 enable", 8'hA8, 32'h11);
    // R5 start
    wr(8'hA8, 32'h3);
    check("R5 pulse", {31'b0, engStart}, 32'h1);
    rd("R5 busy csr", 8'hA8, 32'h1);
    @(negedge clk);
    check("R5 one cycle", {31'b0, engStart}, 32'h0);
    // R6 start while busy
    wr(8'hA8, 32'h3);
    check("R6 busy start", {31'b0, engStart}, 32'h0);
    rd("R6 still busy", 8'hA8, 32'h1);
    // R7 done
    pulseDone();
    check("R7 irq set", {31'b0, irq}, 32'h1);
    rd("R7 idle", 8'hA8, 32'h11);
    @(negedge clk);
    check("R7 sticky", {31'b0, irq}, 32'h1);
    // R6 start with enable 0 in the same write
    wr(8'hA8, 32'h2);
    check("R6 disabled start", {31'b0, engStart}, 32'h0);
    rd("R6 disabled csr", 8'hA8, 32'h10);
    // R8 clear, then clear colliding with done
    wr(8'hA8, 32'h8);
    check("R8 cleared", {31'b0, irq}, 32'h0);
    rd("R8 bit3 reads 0", 8'hA8, 32'h10);
    engDone = 1;
    wr(8'hA8, 32'h8);
    engDone = 0;
    check("R8 done wins", {31'b0, irq}, 32'h1);
    // R9 unmapped and read-only writes
    rd("R9 unmapped 00", 8'h00, 32'h0);
    rd("R9 unmapped 94", 8'h94, 32'h0);
    wr(8'h94, 32'hFFFF_FFFF);
    rd("R9 ignored write size", 8'h8C, 32'h007F_FFFF);
    wr(8'hA8, 32'hFFFF_FFE0);
    rd("R9 reserved csr bits", 8'hA8, 32'h10);
    // Random phase checked against the model every clock
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] offs [4];
      offs[0] = 8'h8C; offs[1] = 8'h90; offs[2] = 8'hA8; offs[3] = 8'($urandom);
      wrEn = ($urandom % 3) == 0;
      wrAddr = offs[($urandom % 8) < 5 ? 2 : $urandom % 4];
      wrData = $urandom;
      if (($urandom % 2) == 0) wrData[0] = 1'b1;
      engDone = ($urandom % 6) == 0;
      rdAddr = offs[$urandom % 4];
      @(negedge clk);
    end
    wrEn = 0; engDone = 0;
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule